// File: doc/BRIEF.md
# Show-Ahead FIFO on Registered-Read Memory

This block is a single-clock queue whose storage is a synchronous-read RAM, the kind of memory that returns data only one edge after the address is presented. Even so, the oldest stored word is visible at the read port whenever the queue holds data, so a consumer samples `rd_data` and pops in the same cycle, with no request-then-wait bubble.

To hide the memory latency, the RAM address is steered one cycle ahead. When a pop is accepted, the address is the entry after the current head, and otherwise it is the head. A word written into an empty queue cannot yet come out of the RAM on the next cycle. The same applies to a word written while the only stored entry is being popped. A one-word bypass register, loaded from the write data on every edge, supplies the head for that single cycle. The producer and consumer are expected to watch `full` and `empty`. A push into a full queue and a pop from an empty one are dropped without side effects.

Top module: `fifo_bram_fwft`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full` is 0 and `level` is 0.
- R2: A push while `full` is 1 is dropped: `level` stays at DEPTH and the stored words and their order are unchanged.
- R3: A pop while `empty` is 1 is dropped: `level` stays 0, and the next pushed word becomes the head.
- R4: `level` equals accepted pushes minus accepted pops and never exceeds DEPTH. `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is DEPTH.
- R5: Whenever `empty` is 0, `rd_data` holds the oldest unpopped word in the same cycle, so words leave in the order they were pushed.
- R6: A word pushed into an empty queue is on `rd_data` in the very next cycle, together with `empty` falling.
- R7: A push and a pop in the same cycle at a level of one keep `level` at one, and the pushed word is the head on the next cycle.
- R8: A push and a pop in the same cycle while full accept only the pop, so `level` becomes DEPTH-1.
- R9: A push and a pop in the same cycle while empty accept only the push, so `level` becomes 1.
- R10: Ordering and flags stay correct across many wraps of both pointers around the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Current head word, valid while `empty` is 0 |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds DEPTH words |
| level | output | LG+1 | Number of stored words |

## Verification
A wrong pointer shows up as a wrong `level` or flag on the cycle after the faulty edge. It also shows up as a head word that breaks push order as soon as that entry reaches the head. A faulty look-ahead address or bypass flag does not corrupt the stored contents. It shows as a stale or wrong `rd_data` for exactly one cycle, right after a pop or right after a push into an empty or single-entry queue. For that reason the head is compared on every cycle the queue is non-empty, and every push/pop combination is applied from every level.

// File: rtl/fifo_bram_pkg.sv
package fifo_bram_pkg;

    // Which source drives the head word on the read port.
    typedef enum logic {
        HEAD_FROM_RAM    = 1'b0,
        HEAD_FROM_BYPASS = 1'b1
    } head_src_e;

endpackage

// File: rtl/fifo_bram_mem.sv
// Simple dual-port storage with a registered read port.
// A read of the address being written in the same edge returns the old word.
module fifo_bram_mem #(
    parameter int DW = 8,
    parameter int LG = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [LG-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [LG-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << LG;

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata_q <= store[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/fifo_bram_ctrl.sv
// Pointer, flag and bypass control for the show-ahead queue.
module fifo_bram_ctrl
    import fifo_bram_pkg::*;
#(
    parameter int DW = 8,
    parameter int LG = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic          ram_we,
    output logic [LG-1:0] ram_waddr,
    output logic [LG-1:0] ram_raddr,
    output logic [DW-1:0] byp_data,
    output head_src_e     head_src,
    output logic [LG:0]   level,
    output logic          empty,
    output logic          full
);
    localparam logic [LG:0] LEVEL_FULL = {1'b1, {LG{1'b0}}};
    localparam logic [LG:0] LEVEL_ONE  = (LG+1)'(1);

    typedef struct packed {
        logic [LG:0]   wptr;
        logic [LG:0]   rptr;
        logic          byp_vld;
        logic [DW-1:0] byp_word;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        push_ok, pop_ok;

    // Status derived from the registered pointers only.
    assign level = st_q.wptr - st_q.rptr;
    assign empty = (level == '0);
    assign full  = (level == LEVEL_FULL);

    assign push_ok = wr_en && !full;
    assign pop_ok  = rd_en && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wptr = st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = st_q.rptr + 1'b1;
        end
        // The bypass copy follows the write bus on every edge.
        st_d.byp_word = wr_data;
        // The bypass holds the head only when the RAM cannot yet return it.
        st_d.byp_vld  = wr_en && (empty || (rd_en && level == LEVEL_ONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Look-ahead address: step past the head when it is being popped.
    assign ram_raddr = st_q.rptr[LG-1:0] + LG'(pop_ok);
    assign ram_waddr = st_q.wptr[LG-1:0];
    assign ram_we    = push_ok;
    assign byp_data  = st_q.byp_word;
    assign head_src  = st_q.byp_vld ? HEAD_FROM_BYPASS : HEAD_FROM_RAM;

endmodule

// File: rtl/fifo_bram_fwft.sv
module fifo_bram_fwft
    import fifo_bram_pkg::*;
#(
    parameter int DW = 8,
    parameter int LG = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic [LG:0]   level
);
    logic          ram_we;
    logic [LG-1:0] ram_waddr;
    logic [LG-1:0] ram_raddr;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] byp_data;
    head_src_e     head_src;

    fifo_bram_ctrl #(.DW(DW), .LG(LG)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_raddr (ram_raddr),
        .byp_data  (byp_data),
        .head_src  (head_src),
        .level     (level),
        .empty     (empty),
        .full      (full)
    );

    fifo_bram_mem #(.DW(DW), .LG(LG)) u_mem (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_data),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    always_comb begin
        rd_data = (head_src == HEAD_FROM_BYPASS) ? byp_data : ram_rdata;
    end

endmodule

// File: rtl/fifo_bram_fwft_chk.sv
module fifo_bram_fwft_chk #(
    parameter int DW = 8,
    parameter int LG = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic          full,
    input logic [LG:0]   level
);
    localparam logic [LG:0] DEPTH_L = {1'b1, {LG{1'b0}}};
    localparam logic [LG:0] ONE_L   = (LG+1)'(1);

    a_r2_push_full_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && level == DEPTH_L));

    a_r3_pop_empty_dropped: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && level == '0));

    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_L);

    a_r4_push_counts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !(rd_en && !empty)) |=> (level == $past(level) + ONE_L));

    a_r4_pop_counts: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && !(wr_en && !full)) |=> (level == $past(level) - ONE_L));

    a_r6_show_ahead: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> (!empty && rd_data == $past(wr_data)));

    a_r7_swap_at_one: assert property (@(posedge clk) disable iff (rst)
        (level == ONE_L && wr_en && rd_en) |=> (level == ONE_L && rd_data == $past(wr_data)));

    a_r8_both_at_full: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> (level == DEPTH_L - ONE_L));

    a_r9_both_at_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en && rd_en) |=> (level == ONE_L));

endmodule

bind fifo_bram_fwft fifo_bram_fwft_chk #(.DW(DW), .LG(LG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (empty),
    .full    (full),
    .level   (level)
);

// File: tb/fifo_bram_fwft_tb.sv
module fifo_bram_fwft_tb;
    localparam int DW    = 8;
    localparam int LG    = 2;
    localparam int DEPTH = 1 << LG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty, full;
    logic [LG:0]   level;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] seq = 8'h10;
    logic [15:0]   lfsr = 16'hACE1;

    always #5 clk = ~clk;

    fifo_bram_fwft #(.DW(DW), .LG(LG)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .full(full), .level(level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every output against the queue model (state before this edge).
    task automatic check_all(input string tag);
        chk({tag, " / R4 level"}, int'(level), model.size());
        chk({tag, " / R4 empty"}, int'(empty), int'(model.size() == 0));
        chk({tag, " / R4 full"},  int'(full),  int'(model.size() == DEPTH));
        if (model.size() != 0) begin
            chk({tag, " / R5 head"}, int'(rd_data), int'(model[0]));
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(input logic w, input logic r, input string tag);
        bit pw, pr;
        @(negedge clk);
        wr_en   = w;
        rd_en   = r;
        wr_data = seq;
        #1;
        check_all(tag);
        pw = w && (model.size() < DEPTH);
        pr = r && (model.size() > 0);
        @(posedge clk);
        if (pr) void'(model.pop_front());
        if (pw) model.push_back(wr_data);
        if (w) seq = seq + 8'd7;
    endtask

    task automatic set_level(input int f, input string tag);
        while (model.size() > 0) step(1'b0, 1'b1, tag);
        for (int i = 0; i < f; i++) step(1'b1, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 full",  int'(full),  0);
        chk("R1 level", int'(level), 0);

        // R3: pops on an empty queue are dropped
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R3 R6 head after push into empty");
        step(1'b0, 1'b1, "R3");
        // R9: push and pop together on an empty queue
        step(1'b1, 1'b1, "R9");
        step(1'b0, 1'b0, "R9 level one");
        // R7: push and pop together at level one
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, "R7");
        step(1'b0, 1'b0, "R7 head is newest");
        // R2: pushes at full dropped, contents intact
        set_level(DEPTH, "R2 fill");
        step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, "R2 still full");
        // R8: push and pop together while full
        step(1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, "R8 level DEPTH-1");
        set_level(0, "R2 drain order");
        step(1'b0, 1'b0, "R2 drained");

        // R6/R10: every push/pop pair from every level
        for (int f = 0; f <= DEPTH; f++) begin
            for (int op = 0; op < 4; op++) begin
                set_level(f, "R10 setup");
                step(op[0], op[1], "R10 sweep op");
                step(1'b0, 1'b0, "R10 sweep result");
                step(1'b0, 1'b1, "R10 sweep pop");
            end
        end

        // R10: long pseudo-random traffic in three biased phases
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                logic w, r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                w = (ph == 0) ? (lfsr[1:0] != 2'b00) : (ph == 1) ? (lfsr[1:0] == 2'b00) : lfsr[0];
                r = (ph == 0) ? (lfsr[3:2] == 2'b00) : (ph == 1) ? (lfsr[3:2] != 2'b00) : lfsr[4];
                step(w, r, "R10 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule